// File: doc/BRIEF.md
# SMBus Block-Read Target Responder

This block answers a single SMBus block-read transaction as a bus target. It watches open-drain clock and data lines through synchronizers. It waits for a write-addressed frame that carries a command byte, then for a repeated start with the read address. Once both arrive, it returns a length byte, the payload bytes and a trailing CRC-8 checksum byte that it computes itself. Payload bytes come from a register-style source: the block presents a byte index and reads the byte from a data input. The length comes from a separate input that is captured when the read phase begins.

Every transaction that gets past its first address byte ends with a one-cycle completion strobe and a latched 4-bit result code. A clean finish gives code 0. Each failure mode has its own code, and the first failure detected decides the code. After an error or a timeout the block releases the data line and returns to idle. Frames that carry a different first address are ignored without any response.

Top module: `smbus_blkrd_target`

## Requirements
- R1: A first address byte whose upper seven bits differ from `tgt_addr_i`, or whose bit 0 is 1, is not acknowledged and produces no completion strobe.
- R2: A matching write address (bit 0 = 0) and a command byte equal to `exp_cmd_i` are both acknowledged by pulling data low in the ninth clock. After a repeated start with a matching read address, the block sends the length byte (value of `blk_len_i`), then the payload bytes `rd_byte_i` for `rd_idx_o` = 0, 1, ..., length-1, most significant bit first.
- R3: The byte after the payload is a CRC-8 (polynomial x^8+x^2+x+1, initial value 0x00, MSB first) over every byte on the bus in order: the write address, the command, the read address, the length and the payload.
- R4: Code 0000 after a master NACK of the checksum byte followed by a stop. The result reads 0000 after reset.
- R5: A command byte other than `exp_cmd_i` is not acknowledged and the transaction ends with code 0011.
- R6: If the block leaves the acknowledge bit of a mismatched command released but samples data low in that clock (collision), the code is 0010.
- R7: After the repeated start, a mismatch in bits [7:1] of the address, or bit 0 = 0 while `dir_check_i` is 1, gives code 0010 with no acknowledge. With `dir_check_i` at 0, a read address with bit 0 = 0 is accepted.
- R8: A master NACK on the length byte or on any payload byte gives code 0100.
- R9: A master ACK on the checksum byte gives code 0010, and so does any further clock after a NACKed checksum byte.
- R10: A start or stop inside a byte, or a stop on a byte boundary before the checksum has been sent, gives code 0010.
- R11: Once the command phase has begun, clock held low for `TIMEOUT_CYC` cycles gives code 0101 and data held low for that long gives code 0110. In both cases the data line is released.
- R12: `done_o` is high for exactly one cycle per completed transaction. `status_o` changes only in that cycle and never takes the value 0001.
- R13: The block starts pulling data low only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| tgt_addr_i | input | 7 | Target address to respond to |
| exp_cmd_i | input | 8 | Expected command code |
| dir_check_i | input | 1 | Require the read bit after the repeated start |
| blk_len_i | input | 8 | Number of payload bytes |
| rd_idx_o | output | 8 | Index of the payload byte being fetched |
| rd_byte_i | input | 8 | Payload byte at `rd_idx_o` |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 4 | Latched result code |

## Verification
The bench builds the block with a 300-cycle timeout limit in place of the 25 ms default. This lets both line-stuck timeouts fire within a few hundred cycles while every normal low phase stays far below the limit. Two synchronizer stages are kept, so the bench drives data changes and samples the acknowledge bit several cycles away from each clock edge. Payload lengths of zero and three cover the shortest frame and a multi-byte frame.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

    typedef enum logic [3:0] {
        RC_OK      = 4'h0,
        RC_PEC     = 4'h1,
        RC_PROTO   = 4'h2,
        RC_HWNACK  = 4'h3,
        RC_EXTNACK = 4'h4,
        RC_SCLTO   = 4'h5,
        RC_SDATO   = 4'h6
    } result_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR1,
        PH_CMD,
        PH_WAITRS,
        PH_ADDR2,
        PH_TX,
        PH_WAITSTOP
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    localparam logic [3:0] BC_BYTE  = 4'd8;   // eight bits seen
    localparam logic [3:0] BC_ACKLO = 4'd9;   // ack slot, clock low
    localparam logic [3:0] BC_ACKHI = 4'd10;  // ack slot, clock high

    localparam logic [7:0] CRC_POLY = 8'h07;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
        logic [7:0] c;
        c = crc ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/smbr_line_sync.sv
module smbr_line_sync
    import smbr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh[0] <= scl_i;
            sda_sh[0] <= sda_i;
            for (int i = 1; i < STAGES; i++) begin
                scl_sh[i] <= scl_sh[i-1];
                sda_sh[i] <= sda_sh[i-1];
            end
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/smbr_timeout.sv
module smbr_timeout #(
    parameter int LIMIT = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic scl,
    input  logic sda,
    output logic scl_to,
    output logic sda_to
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM    = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [1:0] low;
    logic [1:0] fire;

    assign low = {~sda, ~scl};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst || !active || !low[g]) begin
                cnt <= '0;
            end else if (cnt != LIM) begin
                cnt <= cnt + 1'b1;
            end
        end

        assign fire[g] = active & low[g] & (cnt == LIM_M1);

        // R11: one expiry per stuck interval
        p_fire_once_r11: assert property (@(posedge clk) disable iff (rst)
            fire[g] |=> !fire[g]);
    end

    assign scl_to = fire[0];
    assign sda_to = fire[1];

endmodule

// File: rtl/smbr_engine.sv
module smbr_engine
    import smbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic       scl_to,
    input  logic       sda_to,
    input  logic [6:0] tgt_addr,
    input  logic [7:0] exp_cmd,
    input  logic       dir_check,
    input  logic [7:0] blk_len,
    input  logic [7:0] rd_byte,
    output logic       drive_low,
    output logic [7:0] rd_idx,
    output logic       active,
    output logic       done,
    output logic [3:0] status
);

    phase_t     phase;
    logic [3:0] bcnt;
    logic [7:0] shreg;
    logic [7:0] crc;
    logic [7:0] len_q;
    logic [8:0] pos;
    logic       ack_ok;
    logic       drv;
    logic       done_q;
    result_t    status_q;

    logic [7:0] rx_byte;
    logic       last_byte;
    logic       rx_bit;
    logic       mid_cond;
    logic [7:0] next_tx;

    assign rx_byte   = {shreg[6:0], ev.sda};
    assign rx_bit    = ev.scl_rise && (bcnt < BC_BYTE);
    assign mid_cond  = ev.start || ev.stop;
    assign last_byte = (pos == ({1'b0, len_q} + 9'd1));
    assign next_tx   = (pos == {1'b0, len_q}) ? crc : rd_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bcnt     <= '0;
            shreg    <= '0;
            crc      <= '0;
            len_q    <= '0;
            pos      <= '0;
            ack_ok   <= 1'b0;
            drv      <= 1'b0;
            done_q   <= 1'b0;
            status_q <= RC_OK;
        end else begin
            done_q <= 1'b0;
            if (active && (scl_to || sda_to)) begin
                phase    <= PH_IDLE;
                drv      <= 1'b0;
                done_q   <= 1'b1;
                status_q <= scl_to ? RC_SCLTO : RC_SDATO;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        if (ev.start) begin
                            phase <= PH_ADDR1;
                            bcnt  <= '0;
                            crc   <= '0;
                            drv   <= 1'b0;
                        end
                    end

                    PH_ADDR1: begin
                        if (ev.start) begin
                            bcnt <= '0;
                            crc  <= '0;
                        end else if (ev.stop) begin
                            phase <= PH_IDLE;
                        end else if (rx_bit) begin
                            shreg <= rx_byte;
                            bcnt  <= bcnt + 1'b1;
                            if (bcnt == 4'd7) begin
                                if (rx_byte[7:1] == tgt_addr && !rx_byte[0]) begin
                                    crc <= crc8_step(crc, rx_byte);
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                        end else if (ev.scl_fall && bcnt == BC_BYTE) begin
                            drv  <= 1'b1;
                            bcnt <= BC_ACKLO;
                        end else if (ev.scl_rise && bcnt == BC_ACKLO) begin
                            bcnt <= BC_ACKHI;
                        end else if (ev.scl_fall && bcnt == BC_ACKHI) begin
                            drv   <= 1'b0;
                            bcnt  <= '0;
                            phase <= PH_CMD;
                        end
                    end

                    PH_CMD: begin
                        if (mid_cond) begin
                            phase    <= PH_IDLE;
                            drv      <= 1'b0;
                            done_q   <= 1'b1;
                            status_q <= RC_PROTO;
                        end else if (rx_bit) begin
                            shreg <= rx_byte;
                            bcnt  <= bcnt + 1'b1;
                            if (bcnt == 4'd7) begin
                                crc    <= crc8_step(crc, rx_byte);
                                ack_ok <= (rx_byte == exp_cmd);
                            end
                        end else if (ev.scl_fall && bcnt == BC_BYTE) begin
                            drv  <= ack_ok;
                            bcnt <= BC_ACKLO;
                        end else if (ev.scl_rise && bcnt == BC_ACKLO) begin
                            if (!ack_ok) begin
                                phase    <= PH_IDLE;
                                drv      <= 1'b0;
                                done_q   <= 1'b1;
                                status_q <= ev.sda ? RC_HWNACK : RC_PROTO;
                            end else begin
                                bcnt <= BC_ACKHI;
                            end
                        end else if (ev.scl_fall && bcnt == BC_ACKHI) begin
                            drv   <= 1'b0;
                            bcnt  <= '0;
                            phase <= PH_WAITRS;
                        end
                    end

                    PH_WAITRS: begin
                        if (ev.start) begin
                            phase <= PH_ADDR2;
                            bcnt  <= '0;
                        end else if (ev.stop || ev.scl_fall) begin
                            phase    <= PH_IDLE;
                            done_q   <= 1'b1;
                            status_q <= RC_PROTO;
                        end
                    end

                    PH_ADDR2: begin
                        if (mid_cond) begin
                            phase    <= PH_IDLE;
                            drv      <= 1'b0;
                            done_q   <= 1'b1;
                            status_q <= RC_PROTO;
                        end else if (rx_bit) begin
                            shreg <= rx_byte;
                            bcnt  <= bcnt + 1'b1;
                            if (bcnt == 4'd7) begin
                                if (rx_byte[7:1] != tgt_addr || (dir_check && !rx_byte[0])) begin
                                    phase    <= PH_IDLE;
                                    done_q   <= 1'b1;
                                    status_q <= RC_PROTO;
                                end else begin
                                    crc <= crc8_step(crc, rx_byte);
                                end
                            end
                        end else if (ev.scl_fall && bcnt == BC_BYTE) begin
                            drv  <= 1'b1;
                            bcnt <= BC_ACKLO;
                        end else if (ev.scl_rise && bcnt == BC_ACKLO) begin
                            bcnt <= BC_ACKHI;
                        end else if (ev.scl_fall && bcnt == BC_ACKHI) begin
                            shreg <= blk_len;
                            len_q <= blk_len;
                            crc   <= crc8_step(crc, blk_len);
                            pos   <= '0;
                            drv   <= ~blk_len[7];
                            bcnt  <= '0;
                            phase <= PH_TX;
                        end
                    end

                    PH_TX: begin
                        if (mid_cond) begin
                            phase    <= PH_IDLE;
                            drv      <= 1'b0;
                            done_q   <= 1'b1;
                            status_q <= RC_PROTO;
                        end else if (rx_bit) begin
                            bcnt <= bcnt + 1'b1;
                        end else if (ev.scl_fall && bcnt != 4'd0 && bcnt < BC_BYTE) begin
                            shreg <= {shreg[6:0], 1'b0};
                            drv   <= ~shreg[6];
                        end else if (ev.scl_fall && bcnt == BC_BYTE) begin
                            drv  <= 1'b0;
                            bcnt <= BC_ACKLO;
                        end else if (ev.scl_rise && bcnt == BC_ACKLO) begin
                            if (last_byte && !ev.sda) begin
                                phase    <= PH_IDLE;
                                done_q   <= 1'b1;
                                status_q <= RC_PROTO;
                            end else if (!last_byte && ev.sda) begin
                                phase    <= PH_IDLE;
                                done_q   <= 1'b1;
                                status_q <= RC_EXTNACK;
                            end else begin
                                bcnt <= BC_ACKHI;
                            end
                        end else if (ev.scl_fall && bcnt == BC_ACKHI) begin
                            bcnt <= '0;
                            if (last_byte) begin
                                phase <= PH_WAITSTOP;
                            end else begin
                                pos   <= pos + 9'd1;
                                shreg <= next_tx;
                                drv   <= ~next_tx[7];
                                if (pos != {1'b0, len_q}) begin
                                    crc <= crc8_step(crc, rd_byte);
                                end
                            end
                        end
                    end

                    PH_WAITSTOP: begin
                        if (ev.stop) begin
                            phase    <= PH_IDLE;
                            done_q   <= 1'b1;
                            status_q <= RC_OK;
                        end else if (ev.start || ev.scl_fall) begin
                            phase    <= PH_IDLE;
                            done_q   <= 1'b1;
                            status_q <= RC_PROTO;
                        end
                    end

                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign active    = (phase != PH_IDLE) && (phase != PH_ADDR1);
    assign drive_low = drv;
    assign rd_idx    = pos[7:0];
    assign done      = done_q;
    assign status    = status_q;

    // R13: pull-down begins only while the clock is low
    p_pull_on_low_r13: assert property (@(posedge clk) disable iff (rst)
        $rose(drv) |-> !$past(ev.scl));

    // R12: completion strobe lasts one cycle
    p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R12: result code never reports a checksum error and stays in range
    p_code_legal_r12: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (status_q != RC_PEC) && (status_q <= RC_SDATO));

    // R12: result code holds between strobes
    p_status_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(status_q));

    // R11: the line is released when a transaction ends
    p_release_on_end_r11: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !drv);

endmodule

// File: rtl/smbus_blkrd_target.sv
module smbus_blkrd_target
    import smbr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 2_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [6:0] tgt_addr_i,
    input  logic [7:0] exp_cmd_i,
    input  logic       dir_check_i,
    input  logic [7:0] blk_len_i,
    output logic [7:0] rd_idx_o,
    input  logic [7:0] rd_byte_i,
    output logic       done_o,
    output logic [3:0] status_o
);

    line_ev_t ev;
    logic     active;
    logic     scl_to;
    logic     sda_to;

    smbr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smbr_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .scl    (ev.scl),
        .sda    (ev.sda),
        .scl_to (scl_to),
        .sda_to (sda_to)
    );

    smbr_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .scl_to    (scl_to),
        .sda_to    (sda_to),
        .tgt_addr  (tgt_addr_i),
        .exp_cmd   (exp_cmd_i),
        .dir_check (dir_check_i),
        .blk_len   (blk_len_i),
        .rd_byte   (rd_byte_i),
        .drive_low (sda_pull_o),
        .rd_idx    (rd_idx_o),
        .active    (active),
        .done      (done_o),
        .status    (status_o)
    );

endmodule

// File: tb/smbus_blkrd_target_test.sv
module smbus_blkrd_target_test;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 300;
    localparam logic [6:0] ADDR = 7'h2C;
    localparam logic [7:0] CMD  = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       dir_chk = 1'b1;
    logic [7:0] blk_len = 8'd3;
    logic [7:0] rd_idx;
    logic [7:0] rd_byte;
    logic       done;
    logic [3:0] status;
    logic       sda_bus;
    logic [7:0] mem [16];

    int n_chk = 0;
    int n_bad = 0;
    int n_done = 0;
    int base_done = 0;
    int n_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;
    assign rd_byte = mem[rd_idx[3:0]];

    smbus_blkrd_target #(.SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .tgt_addr_i (ADDR),
        .exp_cmd_i  (CMD),
        .dir_check_i(dir_chk),
        .blk_len_i  (blk_len),
        .rd_idx_o   (rd_idx),
        .rd_byte_i  (rd_byte),
        .done_o     (done),
        .status_o   (status)
    );

    always @(posedge clk) if (!rst && done) n_done++;

    // R13 monitor: pull-down must not start while the clock is high
    always @(negedge clk) begin
        if (!rst && scl_m && prev_scl && sda_pull && !prev_pull) n_viol++;
        prev_scl  = scl_m;
        prev_pull = sda_pull;
    end

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[7] ^ b[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic check_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        wait_cyc(3); sda_m = b;
        wait_cyc(7); scl_m = 1'b1;
        wait_cyc(10); scl_m = 1'b0;
    endtask

    task automatic bit_r(output logic b);
        wait_cyc(3); sda_m = 1'b1;
        wait_cyc(6); b = sda_bus;
        wait_cyc(1); scl_m = 1'b1;
        wait_cyc(10); scl_m = 1'b0;
    endtask

    task automatic bus_start;
        wait_cyc(3); sda_m = 1'b1;
        wait_cyc(7); scl_m = 1'b1;
        wait_cyc(10); sda_m = 1'b0;
        wait_cyc(10); scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        wait_cyc(3); sda_m = 1'b0;
        wait_cyc(7); scl_m = 1'b1;
        wait_cyc(10); sda_m = 1'b1;
        wait_cyc(10);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic nacked);
        for (int i = 7; i >= 0; i--) bit_w(v[i]);
        bit_r(nacked);
    endtask

    task automatic read_byte(input logic ackv, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_r(v[i]);
        bit_w(ackv);
    endtask

    task automatic expect_end(input string tag, input int exp_done, input logic [3:0] exp_st, input int wn);
        wait_cyc(wn);
        check_int({tag, " strobe count"}, n_done - base_done, exp_done);
        if (exp_done > 0) check_int({tag, " result code"}, int'(status), int'(exp_st));
        check_int({tag, " line released"}, int'(sda_pull), 0);
        base_done = n_done;
    endtask

    // mode: 0 normal, 1 NACK first payload byte, 2 ACK checksum, 3 extra clock, 4 stop after length
    task automatic read_txn(input string tag, input logic [7:0] a2, input int n, input int mode,
                            input logic [3:0] exp_st);
        logic nk;
        logic [7:0] v;
        logic [7:0] c;
        int bad;
        base_done = n_done;
        blk_len = n[7:0];
        c = 8'h00;
        bus_start;
        write_byte({ADDR, 1'b0}, nk); c = ref_crc(c, {ADDR, 1'b0});
        check_int({tag, " R2 address ack"}, int'(nk), 0);
        write_byte(CMD, nk); c = ref_crc(c, CMD);
        check_int({tag, " R2 command ack"}, int'(nk), 0);
        bus_start;
        write_byte(a2, nk); c = ref_crc(c, a2);
        check_int({tag, " R2 R7 read address ack"}, int'(nk), 0);
        read_byte(1'b0, v); c = ref_crc(c, v);
        check_int({tag, " R2 length byte"}, int'(v), n);
        if (mode == 4) begin
            bus_stop;
            expect_end(tag, 1, exp_st, 40);
            return;
        end
        bad = 0;
        for (int i = 0; i < n; i++) begin
            read_byte((mode == 1) ? 1'b1 : 1'b0, v);
            if (v !== mem[i]) bad++;
            c = ref_crc(c, v);
            if (mode == 1) break;
        end
        if (n > 0) check_int({tag, " R2 payload mismatches"}, bad, 0);
        if (mode == 1) begin
            bus_stop;
            expect_end(tag, 1, exp_st, 40);
            return;
        end
        read_byte((mode == 2) ? 1'b0 : 1'b1, v);
        check_int({tag, " R3 checksum byte"}, int'(v), int'(c));
        if (mode == 3) bit_w(1'b1);
        bus_stop;
        expect_end(tag, 1, exp_st, 40);
    endtask

    task automatic t_reset;
        check_int("R4 reset result code", int'(status), 0);
        check_int("R4 reset strobe", int'(done), 0);
        check_int("R13 reset line released", int'(sda_pull), 0);
    endtask

    task automatic t_foreign_addr;
        logic nk;
        base_done = n_done;
        bus_start;
        write_byte({ADDR ^ 7'h01, 1'b0}, nk);
        check_int("R1 foreign address not acked", int'(nk), 1);
        bus_stop;
        bus_start;
        write_byte({ADDR, 1'b1}, nk);
        check_int("R1 read bit in first address not acked", int'(nk), 1);
        bus_stop;
        expect_end("R1 ignored frames", 0, 4'h0, 40);
    endtask

    task automatic t_cmd_mismatch;
        logic nk;
        base_done = n_done;
        bus_start;
        write_byte({ADDR, 1'b0}, nk);
        write_byte(CMD ^ 8'h10, nk);
        check_int("R5 wrong command not acked", int'(nk), 1);
        bus_stop;
        expect_end("R5 hardware nack", 1, 4'h3, 40);
    endtask

    task automatic t_collision;
        logic nk;
        base_done = n_done;
        bus_start;
        write_byte({ADDR, 1'b0}, nk);
        for (int i = 7; i >= 0; i--) bit_w(CMD[i] ^ (i == 0));
        bit_w(1'b0);
        bus_stop;
        expect_end("R6 collision", 1, 4'h2, 40);
    endtask

    task automatic t_addr2_bad(input string tag, input logic [7:0] a2);
        logic nk;
        base_done = n_done;
        bus_start;
        write_byte({ADDR, 1'b0}, nk);
        write_byte(CMD, nk);
        bus_start;
        write_byte(a2, nk);
        check_int({tag, " not acked"}, int'(nk), 1);
        bus_stop;
        expect_end(tag, 1, 4'h2, 40);
    endtask

    task automatic t_mid_stop;
        logic nk;
        base_done = n_done;
        bus_start;
        write_byte({ADDR, 1'b0}, nk);
        bit_w(1'b0); bit_w(1'b1); bit_w(1'b0);
        bus_stop;
        expect_end("R10 stop inside command byte", 1, 4'h2, 40);
    endtask

    task automatic t_scl_timeout;
        logic nk;
        base_done = n_done;
        bus_start;
        write_byte({ADDR, 1'b0}, nk);
        wait_cyc(TMO + 30);
        check_int("R11 clock-low line released", int'(sda_pull), 0);
        scl_m = 1'b1;
        wait_cyc(10);
        sda_m = 1'b1;
        expect_end("R11 clock-low timeout", 1, 4'h5, 20);
    endtask

    task automatic t_sda_timeout;
        logic nk;
        base_done = n_done;
        bus_start;
        write_byte({ADDR, 1'b0}, nk);
        write_byte(CMD, nk);
        wait_cyc(3); sda_m = 1'b1;
        wait_cyc(7); scl_m = 1'b1;
        wait_cyc(10); sda_m = 1'b0;
        wait_cyc(TMO + 30);
        sda_m = 1'b1;
        expect_end("R11 data-low timeout", 1, 4'h6, 20);
    endtask

    initial begin
        mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'hF0; mem[3] = 8'h81;
        for (int i = 4; i < 16; i++) mem[i] = 8'(i * 17);
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        t_reset;
        read_txn("R4 three-byte read", {ADDR, 1'b1}, 3, 0, 4'h0);
        read_txn("R4 empty read", {ADDR, 1'b1}, 0, 0, 4'h0);
        t_foreign_addr;
        t_cmd_mismatch;
        t_collision;
        t_addr2_bad("R7 read address mismatch", {ADDR ^ 7'h04, 1'b1});
        t_addr2_bad("R7 write bit with check on", {ADDR, 1'b0});
        dir_chk = 1'b0;
        read_txn("R7 write bit with check off", {ADDR, 1'b0}, 3, 0, 4'h0);
        dir_chk = 1'b1;
        read_txn("R8 master nack on payload", {ADDR, 1'b1}, 3, 1, 4'h4);
        read_txn("R9 checksum acked", {ADDR, 1'b1}, 2, 2, 4'h2);
        read_txn("R9 extra clock after checksum", {ADDR, 1'b1}, 1, 3, 4'h2);
        read_txn("R10 early stop after length", {ADDR, 1'b1}, 3, 4, 4'h2);
        t_mid_stop;
        t_scl_timeout;
        t_sda_timeout;
        check_int("R13 pull-down began while clock high", n_viol, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule